// File: doc/BRIEF.md
# Stride-Detecting Hardware Prefetcher

This block watches the stream of demand addresses a cache sees, one address per valid cycle, and works out whether the accesses march through memory with a constant byte gap. It keeps the last address and the last gap. It counts how many gaps in a row have matched. Once enough nonzero gaps agree, the stride is locked. On every later demand that keeps the same gap, the block launches a short burst of prefetch requests ahead of the newest address. The burst leaves through a valid/ready request port.

Until a stride locks, one case still gets help: when the gap is exactly one cache line, the block sends a single request for the line after the newest one. A gap that changes, or a repeated address, cancels the lock and any requests not yet sent. The new gap becomes the candidate. A parameter option moves the burst further ahead, so that the farthest request lies ceil(miss latency / compute cycles per line) strides past the newest address. Two counters report how many requests were accepted and how many of them were later touched by a demand access. Their ratio gives the prefetch accuracy.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset, pf_valid and stride_locked are 0, and pf_issued and pf_useful are 0.
- R2: stride_locked goes to 1 after the demand that completes CONFIRM_DELTAS consecutive equal nonzero gaps (three addresses with one gap, by default). It stays 1 while the same gap keeps arriving.
- R3: On each demand that leaves the stride locked, the block requests latest+1×stride, latest+2×stride, … latest+DEGREE×stride, one at a time and in that order. For example, a latest address of 2144 with stride 48 gives 2192, 2240 and 2288.
- R4: Gaps are taken modulo 2^ADDR_W, so a descending stream locks a negative stride and prefetches at lower addresses.
- R5: When the stride is not locked and the gap is exactly LINE_BYTES, one request is made to the newest address with its low log2(LINE_BYTES) bits cleared, plus LINE_BYTES.
- R6: A gap that differs from the stored one clears the lock, drops any unsent requests, and becomes the new candidate. An irregular stream never raises pf_valid.
- R7: A zero gap (same address twice) clears the lock and produces no request.
- R8: While pf_valid is 1 and pf_ready is 0, with no new demand, pf_valid stays 1 and pf_addr is unchanged.
- R9: A demand arriving mid-burst drops the rest of the old burst. A fresh burst then starts from the new newest address.
- R10: With TIMELY_LEAD set, the whole burst is shifted so the farthest request is ceil(MISS_LATENCY/CYCLES_PER_LINE) strides past the newest address. With 60/4 and degree 3, the offsets are 13, 14 and 15 strides.
- R11: pf_issued grows by exactly one on every cycle with pf_valid and pf_ready both 1.
- R12: pf_useful grows by one when a demand falls in the line of any of the last HIST_DEPTH accepted requests. Those records are then retired, so a second demand to that line adds nothing.
- R13: The first request of a burst is on pf_valid/pf_addr in the cycle right after the demand that triggers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dem_valid | input | 1 | A demand address is present this cycle |
| dem_addr | input | ADDR_W | Demand byte address |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The consumer takes the offered request |
| pf_addr | output | ADDR_W | Prefetch byte address |
| stride_locked | output | 1 | A stride is currently confirmed |
| pf_issued | output | CNT_W | Accepted prefetch requests |
| pf_useful | output | CNT_W | Accepted requests later touched by a demand |

## Verification
Errors in the gap tracker reach the ports in the cycle right after the demand that exposes them. A wrong agreement count makes a burst start one demand too early or too late. A stale or wrong stride puts a bad address on the first request. Errors in the burst sequencer show within a handshake or two: a burst that is too long or too short, an address that moves while the consumer stalls, or an old burst that survives a new demand. Errors in the usefulness history show up only later, when a demand reaches a prefetched line and pf_useful moves wrongly.

// File: rtl/sp_pkg.sv
package sp_pkg;

   typedef enum logic [1:0] {
      BURST_NONE     = 2'd0,
      BURST_STRIDE   = 2'd1,
      BURST_NEXTLINE = 2'd2
   } burst_kind_e;

   function automatic int unsigned width_min1(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sp_stride_detect.sv
module sp_stride_detect
   import sp_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int LINE_BYTES     = 64,
   parameter int CONFIRM_DELTAS = 2,
   parameter int SKIP           = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              obs_valid,
   input  logic [ADDR_W-1:0] obs_addr,
   output burst_kind_e       go_kind,
   output logic [ADDR_W-1:0] go_first,
   output logic [ADDR_W-1:0] go_step,
   output logic              locked
);
   localparam int OFF_W   = $clog2(LINE_BYTES);
   localparam int AGREE_W = width_min1(CONFIRM_DELTAS + 1);
   localparam logic [AGREE_W-1:0] AGREE_MAX = AGREE_W'(CONFIRM_DELTAS);
   localparam logic [ADDR_W-1:0]  LEAD_MUL  = ADDR_W'(SKIP + 1);
   localparam logic [ADDR_W-1:0]  LINE_STEP = ADDR_W'(LINE_BYTES);

   logic               have_last_q;
   logic [ADDR_W-1:0]  last_q;
   logic [ADDR_W-1:0]  stride_q;
   logic [AGREE_W-1:0] agree_q;

   logic [ADDR_W-1:0]  delta;
   logic               nonzero;
   logic               same;
   logic [AGREE_W-1:0] agree_n;
   logic               lock_n;
   logic [ADDR_W-1:0]  line_base;

   always_comb begin
      delta     = obs_addr - last_q;
      nonzero   = have_last_q && (delta != '0);
      same      = nonzero && (delta == stride_q);
      line_base = {obs_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      if (same)
         agree_n = (agree_q >= AGREE_MAX) ? AGREE_MAX : agree_q + AGREE_W'(1);
      else if (nonzero)
         agree_n = AGREE_W'(1);
      else
         agree_n = '0;
      lock_n = (agree_n >= AGREE_MAX);

      go_kind  = BURST_NONE;
      go_first = '0;
      go_step  = '0;
      if (lock_n) begin
         go_kind  = BURST_STRIDE;
         go_step  = delta;
         go_first = obs_addr + LEAD_MUL * delta;
      end else if (nonzero && (delta == LINE_STEP)) begin
         go_kind  = BURST_NEXTLINE;
         go_step  = LINE_STEP;
         go_first = line_base + LEAD_MUL * LINE_STEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_last_q <= 1'b0;
         last_q      <= '0;
         stride_q    <= '0;
         agree_q     <= '0;
      end else if (obs_valid) begin
         have_last_q <= 1'b1;
         last_q      <= obs_addr;
         stride_q    <= nonzero ? delta : '0;
         agree_q     <= agree_n;
      end
   end

   assign locked = (agree_q >= AGREE_MAX);

endmodule

// File: rtl/sp_burst_seq.sv
module sp_burst_seq
   import sp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEGREE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  burst_kind_e       load_kind,
   input  logic [ADDR_W-1:0] load_first,
   input  logic [ADDR_W-1:0] load_step,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic              fire
);
   localparam int CW = width_min1(DEGREE + 1);

   logic [CW-1:0]     remain_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] step_q;
   logic [CW-1:0]     load_cnt;

   always_comb begin
      unique case (load_kind)
         BURST_STRIDE:   load_cnt = CW'(DEGREE);
         BURST_NEXTLINE: load_cnt = CW'(1);
         default:        load_cnt = '0;
      endcase
   end

   assign req_valid = (remain_q != '0);
   assign req_addr  = cur_q;
   assign fire      = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         cur_q    <= '0;
         step_q   <= '0;
      end else if (load) begin
         remain_q <= load_cnt;
         cur_q    <= load_first;
         step_q   <= load_step;
      end else if (fire) begin
         remain_q <= remain_q - CW'(1);
         cur_q    <= cur_q + step_q;
      end
   end

endmodule

// File: rtl/sp_use_track.sv
module sp_use_track
   import sp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int HIST_DEPTH = 8,
   parameter int CNT_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [ADDR_W-1:0] fire_addr,
   input  logic              dem_valid,
   input  logic [ADDR_W-1:0] dem_addr,
   output logic [CNT_W-1:0]  issued_cnt,
   output logic [CNT_W-1:0]  useful_cnt
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam int PW     = width_min1(HIST_DEPTH);
   localparam logic [PW-1:0] LAST_SLOT = PW'(HIST_DEPTH - 1);

   logic [LINE_W-1:0]     line_q [HIST_DEPTH];
   logic [HIST_DEPTH-1:0] vld_q;
   logic [HIST_DEPTH-1:0] vld_n;
   logic [HIST_DEPTH-1:0] hit_vec;
   logic [PW-1:0]         wptr_q;
   logic [LINE_W-1:0]     dem_line;
   logic [LINE_W-1:0]     fire_line;

   assign dem_line  = dem_addr[ADDR_W-1:OFF_W];
   assign fire_line = fire_addr[ADDR_W-1:OFF_W];

   for (genvar i = 0; i < HIST_DEPTH; i++) begin : g_cmp
      assign hit_vec[i] = vld_q[i] && (line_q[i] == dem_line);
   end

   always_comb begin
      vld_n = vld_q;
      if (dem_valid) vld_n = vld_n & ~hit_vec;
      if (fire)      vld_n[wptr_q] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q      <= '0;
         wptr_q     <= '0;
         issued_cnt <= '0;
         useful_cnt <= '0;
         for (int i = 0; i < HIST_DEPTH; i++) line_q[i] <= '0;
      end else begin
         vld_q <= vld_n;
         if (fire) begin
            line_q[wptr_q] <= fire_line;
            wptr_q         <= (wptr_q == LAST_SLOT) ? '0 : wptr_q + PW'(1);
            issued_cnt     <= issued_cnt + CNT_W'(1);
         end
         if (dem_valid && (hit_vec != '0))
            useful_cnt <= useful_cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
   import sp_pkg::*;
#(
   parameter int ADDR_W          = 32,
   parameter int LINE_BYTES      = 64,
   parameter int DEGREE          = 3,
   parameter int CONFIRM_DELTAS  = 2,
   parameter int EXTRA_OFFSET    = 0,
   parameter bit TIMELY_LEAD     = 1'b0,
   parameter int MISS_LATENCY    = 60,
   parameter int CYCLES_PER_LINE = 4,
   parameter int HIST_DEPTH      = 8,
   parameter int CNT_W           = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dem_valid,
   input  logic [ADDR_W-1:0] dem_addr,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [ADDR_W-1:0] pf_addr,
   output logic              stride_locked,
   output logic [CNT_W-1:0]  pf_issued,
   output logic [CNT_W-1:0]  pf_useful
);
   localparam int LEAD_LINES = (MISS_LATENCY + CYCLES_PER_LINE - 1) / CYCLES_PER_LINE;
   localparam int TIMED_SKIP = (LEAD_LINES > DEGREE) ? (LEAD_LINES - DEGREE) : 0;
   localparam int SKIP       = EXTRA_OFFSET + (TIMELY_LEAD ? TIMED_SKIP : 0);

   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two, at least 2");
   end
   if (ADDR_W <= $clog2(LINE_BYTES)) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end
   if (DEGREE < 1 || CONFIRM_DELTAS < 1 || HIST_DEPTH < 1) begin : g_bad_count
      $error("DEGREE, CONFIRM_DELTAS and HIST_DEPTH must be at least 1");
   end
   if (CYCLES_PER_LINE < 1 || EXTRA_OFFSET < 0 || CNT_W < 1) begin : g_bad_timing
      $error("CYCLES_PER_LINE and CNT_W must be positive, EXTRA_OFFSET non-negative");
   end

   burst_kind_e       go_kind;
   logic [ADDR_W-1:0] go_first;
   logic [ADDR_W-1:0] go_step;
   logic              fire;

   sp_stride_detect #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
      .CONFIRM_DELTAS(CONFIRM_DELTAS), .SKIP(SKIP)
   ) u_detect (
      .clk(clk), .rst_n(rst_n),
      .obs_valid(dem_valid), .obs_addr(dem_addr),
      .go_kind(go_kind), .go_first(go_first), .go_step(go_step),
      .locked(stride_locked)
   );

   sp_burst_seq #(
      .ADDR_W(ADDR_W), .DEGREE(DEGREE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .load(dem_valid), .load_kind(go_kind),
      .load_first(go_first), .load_step(go_step),
      .req_valid(pf_valid), .req_ready(pf_ready), .req_addr(pf_addr),
      .fire(fire)
   );

   sp_use_track #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
      .HIST_DEPTH(HIST_DEPTH), .CNT_W(CNT_W)
   ) u_track (
      .clk(clk), .rst_n(rst_n),
      .fire(fire), .fire_addr(pf_addr),
      .dem_valid(dem_valid), .dem_addr(dem_addr),
      .issued_cnt(pf_issued), .useful_cnt(pf_useful)
   );

endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
   parameter int ADDR_W = 32,
   parameter int DEGREE = 3,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dem_valid,
   input logic [ADDR_W-1:0] dem_addr,
   input logic              pf_valid,
   input logic              pf_ready,
   input logic [ADDR_W-1:0] pf_addr,
   input logic              stride_locked,
   input logic [CNT_W-1:0]  pf_issued,
   input logic [CNT_W-1:0]  pf_useful
);
   logic              prev_ok;
   logic [ADDR_W-1:0] prev_addr;
   logic [7:0]        fires_since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ok     <= 1'b0;
         prev_addr   <= '0;
         fires_since <= '0;
      end else begin
         if (dem_valid) begin
            prev_ok   <= 1'b1;
            prev_addr <= dem_addr;
         end
         if (dem_valid)
            fires_since <= '0;
         else if (pf_valid && pf_ready && fires_since != 8'hFF)
            fires_since <= fires_since + 8'd1;
      end
   end

   // R8: an offered request waits unchanged for the consumer
   a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready && !dem_valid) |=> (pf_valid && $stable(pf_addr)));

   // R11: the issue counter tracks handshakes one for one
   a_r11_count_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && pf_ready) |=> (pf_issued == $past(pf_issued) + CNT_W'(1)));

   a_r11_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      !(pf_valid && pf_ready) |=> $stable(pf_issued));

   // R7: a repeated address leaves nothing offered and no lock
   a_r7_zero_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (dem_valid && prev_ok && dem_addr == prev_addr) |=> (!pf_valid && !stride_locked));

   // R9: a burst never exceeds DEGREE accepted requests between demands
   a_r9_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fires_since <= 8'(DEGREE));

   // R12: useful prefetches never outnumber issued ones
   a_r12_useful_le_issued: assert property (@(posedge clk) disable iff (!rst_n)
      pf_useful <= pf_issued);

endmodule

bind stride_prefetcher sp_checker #(
   .ADDR_W(ADDR_W), .DEGREE(DEGREE), .CNT_W(CNT_W)
) u_sp_checker (
   .clk(clk), .rst_n(rst_n),
   .dem_valid(dem_valid), .dem_addr(dem_addr),
   .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
   .stride_locked(stride_locked),
   .pf_issued(pf_issued), .pf_useful(pf_useful)
);

// File: tb/tb_stride_prefetcher.sv
module tb_stride_prefetcher;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dem_valid = 1'b0;
   logic [AW-1:0] dem_addr = '0;
   logic          pf_ready = 1'b0;
   logic          pf_ready2 = 1'b0;
   logic          pf_valid, pf_valid2;
   logic [AW-1:0] pf_addr, pf_addr2;
   logic          stride_locked, stride_locked2;
   logic [15:0]   pf_issued, pf_issued2, pf_useful, pf_useful2;

   int tests = 0;
   int fails = 0;
   int exp_issued = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stride_prefetcher dut (
      .clk(clk), .rst_n(rst_n), .dem_valid(dem_valid), .dem_addr(dem_addr),
      .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
      .stride_locked(stride_locked), .pf_issued(pf_issued), .pf_useful(pf_useful)
   );

   stride_prefetcher #(.TIMELY_LEAD(1'b1), .MISS_LATENCY(60), .CYCLES_PER_LINE(4)) dut2 (
      .clk(clk), .rst_n(rst_n), .dem_valid(dem_valid), .dem_addr(dem_addr),
      .pf_valid(pf_valid2), .pf_ready(pf_ready2), .pf_addr(pf_addr2),
      .stride_locked(stride_locked2), .pf_issued(pf_issued2), .pf_useful(pf_useful2)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
      chk(act == exp, req, what, act, exp);
   endtask

   task automatic send(input logic [AW-1:0] a);
      dem_valid = 1'b1;
      dem_addr  = a;
      @(negedge clk);
      dem_valid = 1'b0;
   endtask

   task automatic quiet(input string req);
      chk_eq(req, "pf_valid idle", pf_valid, 0);
   endtask

   task automatic take(input logic [AW-1:0] exp, input string req);
      chk_eq(req, "pf_valid offered", pf_valid, 1);
      chk_eq(req, "pf_addr", pf_addr, exp);
      pf_ready = 1'b1;
      @(negedge clk);
      pf_ready = 1'b0;
      exp_issued++;
      chk_eq("R11", "pf_issued", pf_issued, exp_issued);
   endtask

   task automatic take2(input logic [AW-1:0] exp, input string req);
      chk_eq(req, "timely pf_valid", pf_valid2, 1);
      chk_eq(req, "timely pf_addr", pf_addr2, exp);
      pf_ready2 = 1'b1;
      @(negedge clk);
      pf_ready2 = 1'b0;
   endtask

   task automatic t_reset();
      chk_eq("R1", "pf_valid", pf_valid, 0);
      chk_eq("R1", "stride_locked", stride_locked, 0);
      chk_eq("R1", "pf_issued", pf_issued, 0);
      chk_eq("R1", "pf_useful", pf_useful, 0);
   endtask

   task automatic t_stride_basic();
      send(2048);
      quiet("R2");
      chk_eq("R2", "locked after one address", stride_locked, 0);
      send(2096);
      quiet("R2");
      chk_eq("R2", "locked after one gap", stride_locked, 0);
      send(2144);
      chk_eq("R2", "locked after two gaps", stride_locked, 1);
      // R13: first request is up the cycle after the triggering demand
      take(2192, "R13");
      take(2240, "R3");
      take(2288, "R3");
      quiet("R3");
   endtask

   task automatic t_useful();
      logic [15:0] u0;
      u0 = pf_useful;
      send(2250);
      chk_eq("R12", "useful after hit", pf_useful, u0 + 1);
      chk_eq("R6", "lock cleared by new gap", stride_locked, 0);
      quiet("R6");
      send(2260);
      chk_eq("R12", "useful after retired line", pf_useful, u0 + 1);
   endtask

   task automatic t_irregular_restart();
      send(5000); quiet("R6");
      send(5300); quiet("R6");
      send(5310); quiet("R6");
      send(5900); quiet("R6");
      chk_eq("R6", "irregular lock", stride_locked, 0);
      send(6100); quiet("R6");
      send(6300);
      chk_eq("R6", "candidate gap locks", stride_locked, 1);
      take(6500, "R9");
      send(6500);
      take(6700, "R9");
      take(6900, "R9");
      take(7100, "R9");
      quiet("R9");
      send(6700);
      chk_eq("R3", "burst pending", pf_valid, 1);
      send(6710);
      quiet("R6");
      chk_eq("R6", "lock dropped mid-burst", stride_locked, 0);
   endtask

   task automatic t_zero();
      send(8000);
      send(8100);
      send(8200);
      chk_eq("R2", "lock before repeat", stride_locked, 1);
      send(8200);
      quiet("R7");
      chk_eq("R7", "lock after repeat", stride_locked, 0);
      send(8200);
      quiet("R7");
   endtask

   task automatic t_hold();
      send(9000);
      send(9080);
      send(9160);
      for (int i = 0; i < 5; i++) begin
         chk_eq("R8", "held valid", pf_valid, 1);
         chk_eq("R8", "held addr", pf_addr, 9240);
         @(negedge clk);
      end
      take(9240, "R8");
      take(9320, "R3");
      take(9400, "R3");
      quiet("R3");
   endtask

   task automatic t_nextline();
      send(20010);
      quiet("R5");
      send(20074);
      chk_eq("R5", "not locked on first line gap", stride_locked, 0);
      take(20096, "R5");
      quiet("R5");
      send(20138);
      chk_eq("R2", "line gap locks", stride_locked, 1);
      take(20202, "R3");
      take(20266, "R3");
      take(20330, "R3");
      quiet("R3");
   endtask

   task automatic t_negative();
      send(30000);
      send(29900);
      send(29800);
      chk_eq("R4", "descending locks", stride_locked, 1);
      take(29700, "R4");
      take(29600, "R4");
      take(29500, "R4");
      quiet("R4");
   endtask

   task automatic t_timely();
      send(50000);
      send(50100);
      send(50200);
      chk_eq("R10", "timely lock", stride_locked2, 1);
      take2(51500, "R10");
      take2(51600, "R10");
      take2(51700, "R10");
      chk_eq("R10", "timely burst ends", pf_valid2, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stride_basic();
      t_useful();
      t_irregular_restart();
      t_zero();
      t_hold();
      t_nextline();
      t_negative();
      t_timely();
      chk_eq("R11", "final issued", pf_issued, exp_issued);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog (all R): actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule